// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block controls single conversions of a successive-approximation ADC with three inputs. Software reaches it over a simple 32-bit register bus: one write strobe, a word address, write data and a combinational read-data path. A conversion moves through three phases: startup, sampling and comparison. The phases are counted in periods of a conversion clock that is divided down from the bus clock. When the comparison phase ends, the block places a 12-bit code and a valid flag into the result register of the channel that was selected. It then raises a sticky completion flag, which can drive an interrupt line.

The analog front end is not part of this block. Each channel instead presents a digital code on `ain_code`. The sequencer takes the selected channel's code at the last conversion-clock period of the sampling window and publishes it when the conversion completes. Every phase length and the divider are programmed as value-minus-one fields. One conversion therefore takes ((startup+1)+(sample+1)+(compare+1))·(div+1) bus-clock cycles.

Top module: `sarc_sequencer`

## Requirements
- R1: After reset, every mapped register reads zero, and `irq` and the busy flag are low.
- R2: A write to the control word (0x04) starts a conversion only when bit 0 changes from 0 to 1, exactly one of the select bits [7:5] is set (bit 5+n picks channel n), and no conversion is running. Writing bit 0 as 1 while it already reads 1 starts nothing. The control word reads back only bits 0 and 7:5.
- R3: An enable edge written with no select bit, or with more than one, starts nothing. Busy stays low and every result register keeps its contents.
- R4: Busy (bit 0 at 0x08) rises at the write edge that starts a conversion and stays high for exactly ((S+1)+(W+1)+(C+1))·(D+1) cycles. The fields come from the timing word at 0x0C: S in [4:0], W in [11:8], D in [15:12] and C in [19:16]. The values in force are those present when the conversion starts.
- R5: The timing word reads back only bits [4:0], [11:8], [15:12] and [19:16]. All other bits read zero.
- R6: The result word of channel n is at 0x14+4n. Bits [11:0] hold the code and bit 15 is the valid flag. A start on channel n clears that channel's valid flag. The flag sets again, together with the new code, at the edge where busy falls. Other channels are left unchanged.
- R7: The published code is the channel's `ain_code` value at the last conversion-clock period of the sampling window. Changes to the input after that edge do not alter the result.
- R8: Completion sets the status flag (bit 0 at 0x28). The flag stays set until a 1 is written to bit 0 at 0x24. Writing 0 there leaves it set.
- R9: `irq` is high exactly when the status flag and the enable bit (bit 0 at 0x20) are both set.
- R10: Reads from unmapped offsets, and from the write-only clear offset 0x24, return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ain_code | input | NCH*CODE_W | Digital sample per channel; channel n at bits [n*CODE_W +: CODE_W] |
| irq | output | 1 | Completion interrupt, gated by the enable bit |

## Verification
The bench builds the block with its default parameters: three channels, 12-bit codes and an 8-bit offset. With these values every channel offset, the 5-bit startup field up to its maximum of 31, and the largest divider setting can all be reached in a few hundred cycles per conversion. Conversions range from the shortest possible (all fields zero, three cycles) to a long, unevenly divided one. The input is swapped one cycle on either side of the capture edge, which pins down the sampling instant. The interrupt gating is exercised with the enable bit both off and on.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

  localparam logic [7:0] OFF_CTRL = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_TIME = 8'h0C;
  localparam logic [7:0] OFF_RES0 = 8'h14;
  localparam logic [7:0] OFF_IEN  = 8'h20;
  localparam logic [7:0] OFF_ICLR = 8'h24;
  localparam logic [7:0] OFF_ISTA = 8'h28;

  localparam int SEL_LSB   = 5;
  localparam int VALID_BIT = 15;

  localparam int STUP_W = 5;
  localparam int SMP_W  = 4;
  localparam int DIV_W  = 4;
  localparam int CMP_W  = 4;
  localparam int STUP_LSB = 0;
  localparam int SMP_LSB  = 8;
  localparam int DIV_LSB  = 12;
  localparam int CMP_LSB  = 16;
  localparam int PHC_W = STUP_W;

  typedef struct packed {
    logic [CMP_W-1:0]  cmp;
    logic [DIV_W-1:0]  div;
    logic [SMP_W-1:0]  smp;
    logic [STUP_W-1:0] stup;
  } time_cfg_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_STARTUP,
    PH_SAMPLE,
    PH_COMPARE
  } phase_e;

  function automatic time_cfg_t cfg_from_word(input logic [31:0] w);
    time_cfg_t r;
    r.stup = w[STUP_LSB +: STUP_W];
    r.smp  = w[SMP_LSB  +: SMP_W];
    r.div  = w[DIV_LSB  +: DIV_W];
    r.cmp  = w[CMP_LSB  +: CMP_W];
    return r;
  endfunction

  function automatic logic [31:0] cfg_to_word(input time_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[STUP_LSB +: STUP_W] = c.stup;
    w[SMP_LSB  +: SMP_W]  = c.smp;
    w[DIV_LSB  +: DIV_W]  = c.div;
    w[CMP_LSB  +: CMP_W]  = c.cmp;
    return w;
  endfunction

  // Last count value of a phase (field value; phase lasts field+1 ticks)
  function automatic logic [PHC_W-1:0] phase_last(input time_cfg_t c, input phase_e p);
    case (p)
      PH_STARTUP: return PHC_W'(c.stup);
      PH_SAMPLE:  return PHC_W'(c.smp);
      PH_COMPARE: return PHC_W'(c.cmp);
      default:    return '0;
    endcase
  endfunction

  function automatic phase_e phase_next(input phase_e p);
    case (p)
      PH_STARTUP: return PH_SAMPLE;
      PH_SAMPLE:  return PH_COMPARE;
      default:    return PH_IDLE;
    endcase
  endfunction

  // Bus-clock cycles from start edge to completion edge
  function automatic int unsigned conv_cycles(input time_cfg_t c);
    return (32'(c.stup) + 32'(c.smp) + 32'(c.cmp) + 32'd3) * (32'(c.div) + 32'd1);
  endfunction

endpackage

// File: rtl/sarc_clkdiv.sv
module sarc_clkdiv #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == div);
  assign tick   = run && !restart && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || restart || at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sarc_phase_fsm.sv
module sarc_phase_fsm
  import sarc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      tick,
  input  time_cfg_t cfg,
  output logic      sample_end,
  output logic      conv_done,
  output logic      busy
);

  phase_e           ph_q;
  logic [PHC_W-1:0] cnt_q;
  logic             last_tick;

  assign busy       = (ph_q != PH_IDLE);
  assign last_tick  = tick && busy && (cnt_q == phase_last(cfg, ph_q));
  assign sample_end = last_tick && (ph_q == PH_SAMPLE);
  assign conv_done  = last_tick && (ph_q == PH_COMPARE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (start) begin
      ph_q  <= PH_STARTUP;
      cnt_q <= '0;
    end else if (tick && busy) begin
      if (last_tick) begin
        ph_q  <= phase_next(ph_q);
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sarc_result_slot.sv
module sarc_result_slot #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  output logic              valid,
  output logic [CODE_W-1:0] code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      code  <= '0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      code  <= code_in;
    end
  end

endmodule

// File: rtl/sarc_sequencer.sv
module sarc_sequencer
  import sarc_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NCH*CODE_W-1:0] ain_code,
  output logic                  irq
);

  localparam logic [31:0] SEL_MASK  = ((32'd1 << NCH) - 32'd1) << SEL_LSB;
  localparam logic [31:0] CTRL_MASK = SEL_MASK | 32'd1;

  // Named internal events (observed by the bound checker)
  logic            wr_ctrl, wr_time, wr_ien, wr_iclr;
  logic            en_rise, start_evt, bad_req, clr_evt;
  logic            sample_evt, done_evt, busy, div_tick;
  logic [NCH-1:0]  req_sel;

  logic [31:0]     ctrl_q;
  time_cfg_t       cfg_q, cfg_run;
  logic            int_en_q, int_sta_q;
  logic [NCH-1:0]  chan_oh_q;
  logic [CODE_W-1:0] samp_q, sel_code;
  logic [NCH-1:0]  res_valid;
  logic [CODE_W-1:0] res_code [NCH];

  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_time = bus_we && (bus_addr == ADDR_W'(OFF_TIME));
  assign wr_ien  = bus_we && (bus_addr == ADDR_W'(OFF_IEN));
  assign wr_iclr = bus_we && (bus_addr == ADDR_W'(OFF_ICLR));

  assign req_sel   = bus_wdata[SEL_LSB +: NCH];
  assign en_rise   = wr_ctrl && bus_wdata[0] && !ctrl_q[0];
  assign start_evt = en_rise && ($countones(req_sel) == 1) && !busy;
  assign bad_req   = en_rise && ($countones(req_sel) != 1);
  assign clr_evt   = wr_iclr && bus_wdata[0];

  // Register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cfg_q    <= '0;
      int_en_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q   <= bus_wdata & CTRL_MASK;
      if (wr_time) cfg_q    <= cfg_from_word(bus_wdata);
      if (wr_ien)  int_en_q <= bus_wdata[0];
    end
  end

  // Conversion context: timing snapshot and channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_run   <= '0;
      chan_oh_q <= '0;
    end else if (start_evt) begin
      cfg_run   <= cfg_q;
      chan_oh_q <= req_sel;
    end
  end

  sarc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .restart (start_evt),
    .div     (cfg_run.div),
    .tick    (div_tick)
  );

  sarc_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_evt),
    .tick       (div_tick),
    .cfg        (cfg_run),
    .sample_end (sample_evt),
    .conv_done  (done_evt),
    .busy       (busy)
  );

  // Input select and sample capture
  always_comb begin
    sel_code = '0;
    for (int n = 0; n < NCH; n++) begin
      if (chan_oh_q[n]) sel_code = ain_code[n*CODE_W +: CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          samp_q <= '0;
    else if (sample_evt) samp_q <= sel_code;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    sarc_result_slot #(.CODE_W(CODE_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_evt && req_sel[g]),
      .load    (done_evt && chan_oh_q[g]),
      .code_in (samp_q),
      .valid   (res_valid[g]),
      .code    (res_code[g])
    );
  end

  // Completion flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        int_sta_q <= 1'b0;
    else if (done_evt) int_sta_q <= 1'b1;
    else if (clr_evt)  int_sta_q <= 1'b0;
  end

  assign irq = int_sta_q && int_en_q;

  // Read path
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = ctrl_q;
    if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata[0] = busy;
    if (bus_addr == ADDR_W'(OFF_TIME)) bus_rdata = cfg_to_word(cfg_q);
    if (bus_addr == ADDR_W'(OFF_IEN))  bus_rdata[0] = int_en_q;
    if (bus_addr == ADDR_W'(OFF_ISTA)) bus_rdata[0] = int_sta_q;
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ADDR_W'(32'(OFF_RES0) + 32'(4 * n))) begin
        bus_rdata[CODE_W-1:0] = res_code[n];
        bus_rdata[VALID_BIT]  = res_valid[n];
      end
    end
  end

endmodule

// File: rtl/sarc_checker.sv
module sarc_checker
  import sarc_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_evt,
  input logic           bad_req,
  input logic           done_evt,
  input logic           clr_evt,
  input logic           busy,
  input logic [NCH-1:0] chan_oh,
  input logic [NCH-1:0] res_valid,
  input logic           int_sta,
  input time_cfg_t      cfg_run
);

  logic [31:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_cnt <= '0;
    else if (start_evt) busy_cnt <= '0;
    else if (busy)      busy_cnt <= busy_cnt + 32'd1;
  end

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  a_r2_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_oh));

  a_r3_bad_select_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_req && !busy) |=> !busy);

  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);

  a_r4_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (busy_cnt + 32'd1 == conv_cycles(cfg_run)));

  a_r6_valid_drops_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> ((res_valid & chan_oh) == '0));

  a_r6_valid_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> ((res_valid & chan_oh) != '0));

  a_r8_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> int_sta);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sta && !clr_evt) |=> int_sta);

endmodule

bind sarc_sequencer sarc_checker #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_evt (start_evt),
  .bad_req   (bad_req),
  .done_evt  (done_evt),
  .clr_evt   (clr_evt),
  .busy      (busy),
  .chan_oh   (chan_oh_q),
  .res_valid (res_valid),
  .int_sta   (int_sta_q),
  .cfg_run   (cfg_run)
);

// File: tb/sarc_sequencer_bench.sv
module sarc_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int CW  = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_we = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH*CW-1:0] ain_code = '0;
  logic            irq;

  sarc_sequencer u_sarc_sequencer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ain_code  (ain_code),
    .irq       (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  int t_start = 0;
  int done_cnt = 0;
  bit mon_on = 1'b1;
  logic irq_prev = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic int conv_len(input int st, input int sw, input int dv, input int cp);
    int per_tick;
    per_tick = dv + 1;
    return per_tick * (st + 1) + per_tick * (sw + 1) + per_tick * (cp + 1);
  endfunction

  function automatic logic [31:0] time_word(input int st, input int sw, input int dv, input int cp);
    return (32'(cp) << 16) | (32'(dv) << 12) | (32'(sw) << 8) | 32'(st);
  endfunction

  // Scoreboard monitor: each completion pops the expected length
  always @(negedge clk) begin : mon
    int e;
    if (mon_on && irq && !irq_prev) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected completion", 32'd1, 32'd0);
      end else begin
        e = exp_q.pop_front();
        check("R4 conversion length", 32'(cyc - t_start), 32'(e));
      end
      done_cnt++;
    end
    irq_prev <= irq;
  end

  // Driver: one conversion, optional input swap at a cycle offset
  task automatic convert(input int ch, input logic [CW-1:0] code0, input int swap_at,
                         input logic [CW-1:0] code1, input logic [CW-1:0] exp_code,
                         input int st, input int sw, input int dv, input int cp);
    logic [31:0] d;
    int prev;
    ain_code[ch*CW +: CW] = code0;
    wr(8'h0C, time_word(st, sw, dv, cp));
    wr(8'h04, 32'h0);
    exp_q.push_back(conv_len(st, sw, dv, cp));
    prev = done_cnt;
    wr(8'h04, 32'h1 | (32'h1 << (5 + ch)));
    t_start = cyc;
    rd(8'h08, d);
    check("R4 busy during conversion", d, 32'h1);
    rd(8'h14 + 8'(4 * ch), d);
    check("R6 valid cleared at start", {16'h0, d[15], 15'h0}, 32'h0);
    if (swap_at > 0) begin
      while (cyc < t_start + swap_at) @(negedge clk);
      ain_code[ch*CW +: CW] = code1;
    end
    while (done_cnt == prev) @(negedge clk);
    rd(8'h08, d);
    check("R4 busy low after completion", d, 32'h0);
    rd(8'h14 + 8'(4 * ch), d);
    check("R6 R7 result word", d, 32'h8000 | 32'(exp_code));
    rd(8'h28, d);
    check("R8 completion flag set", d, 32'h1);
    wr(8'h24, 32'h1);
    rd(8'h28, d);
    check("R8 flag cleared by write-one", d, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    foreach (exp_q[i]) exp_q.delete(i);
    for (int a = 4; a <= 8'h28; a += 4) begin
      rd(8'(a), d);
      check("R1 reset read zero", d, 32'h0);
    end
    check("R1 irq low after reset", 32'(irq), 32'h0);

    // R9: enable interrupt
    wr(8'h20, 32'h1);
    rd(8'h20, d);
    check("R9 enable reads back", d, 32'h1);

    // R5: timing word mask
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d);
    check("R5 timing readback mask", d, 32'h000F_FF1F);

    // R2 R4 R6 R8: shortest, typical and long uneven conversions
    convert(0, 12'hABC, 0, 12'h000, 12'hABC, 0, 0, 0, 0);
    convert(1, 12'h123, 0, 12'h000, 12'h123, 15, 15, 1, 15);
    convert(2, 12'hFFF, 0, 12'h000, 12'hFFF, 31, 3, 2, 5);
    convert(1, 12'h05A, 0, 12'h000, 12'h05A, 2, 1, 15, 0);

    // R6: other channels untouched
    rd(8'h14, d);
    check("R6 channel 0 kept", d, 32'h8ABC);
    rd(8'h1C, d);
    check("R6 channel 2 kept", d, 32'h8FFF);

    // R2: enable already set, second write starts nothing
    wr(8'h04, 32'h1 | (32'h1 << 5));
    rd(8'h08, d);
    check("R2 no start without 0-to-1 edge", d, 32'h0);
    rd(8'h14, d);
    check("R2 channel 0 valid kept", d, 32'h8ABC);

    // R3: no select / several selects
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h1);
    rd(8'h08, d);
    check("R3 no select keeps idle", d, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h08, d);
    check("R3 multi select keeps idle", d, 32'h0);
    rd(8'h04, d);
    check("R2 control readback mask", d, 32'h0000_00E1);
    rd(8'h18, d);
    check("R3 results untouched", d, 32'h805A);
    check("R3 no completion flag", 32'(irq), 32'h0);

    // R7: input swap one cycle before and right after capture edge
    // capture edge at start + (1+1 + 3+1)*(1+1) = 12
    convert(2, 12'h111, 11, 12'h222, 12'h222, 1, 3, 1, 3);
    convert(2, 12'h333, 12, 12'h444, 12'h333, 1, 3, 1, 3);

    // R8 R9: enable off, flag held, write of zero does not clear
    mon_on = 1'b0;
    wr(8'h20, 32'h0);
    wr(8'h0C, time_word(0, 0, 0, 0));
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h1 | (32'h1 << 5));
    d = '0;
    while (d[0] == 1'b0) rd(8'h28, d);
    check("R9 irq masked while disabled", 32'(irq), 32'h0);
    wr(8'h20, 32'h1);
    check("R9 irq follows enable", 32'(irq), 32'h1);
    wr(8'h24, 32'h0);
    rd(8'h28, d);
    check("R8 writing zero keeps flag", d, 32'h1);
    wr(8'h24, 32'h1);
    check("R9 irq drops after clear", 32'(irq), 32'h0);
    mon_on = 1'b1;

    // R10: unmapped accesses
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h10, d);
    check("R10 unmapped read zero", d, 32'h0);
    rd(8'h30, d);
    check("R10 unmapped read zero", d, 32'h0);
    rd(8'h24, d);
    check("R10 clear offset reads zero", d, 32'h0);
    rd(8'h0C, d);
    check("R10 timing word unchanged", d, 32'h0);
    rd(8'h20, d);
    check("R10 enable unchanged", d, 32'h1);
    rd(8'h04, d);
    check("R10 control unchanged", d, 32'h21);

    check("R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule